// File: doc/BRIEF.md
# Byte-Lane Switching-Noise Pattern Tester

This block is a self-running memory test sequencer. It looks for simultaneous switching noise confined to individual byte lanes of a 32-bit data path. A single start pulse launches the test at a chosen base address. For every byte value from 0x00 up to 0xFF, the block builds a word that carries that byte in every lane. It writes that word to the base address and writes its bitwise complement to the next word. It then reads both words back and compares them against what was written. Between the two adjacent words, every data line of every lane toggles, and this full swing is what stresses the lane.

The block talks to memory through a plain request/acknowledge port. The request is held until acknowledged, and read data is taken in the acknowledge cycle. When a comparison fails, the sequencer stops at once. It keeps the failing address, the expected word, the observed word and a per-lane mismatch mask until the next start. A one-cycle done pulse closes every run, whether it passes or fails.

The control is a state machine with six states:
- `ST_IDLE`: waits for start. Start leads to `ST_WR_PAT`.
- `ST_WR_PAT`: writes the pattern word at base. Acknowledge leads to `ST_WR_INV`.
- `ST_WR_INV`: writes the complement at base+4. Acknowledge leads to `ST_RD_PAT`.
- `ST_RD_PAT`: reads base. On acknowledge, a mismatch leads to `ST_FINISH`; otherwise the state moves to `ST_RD_INV`.
- `ST_RD_INV`: reads base+4. On acknowledge, a mismatch or the final byte value leads to `ST_FINISH`. Otherwise the byte value steps and the state returns to `ST_WR_PAT`.
- `ST_FINISH`: raises done for one cycle and always returns to `ST_IDLE`.

Top module: `bytelane_noise_tester`

## Requirements
- R1: A start pulse seen in idle captures `base_addr`. `busy` is high from the next cycle. The first memory access is a write of 0x00000000 to the captured base.
- R2: Every pattern word carries the current byte value in all four byte lanes, so it equals byte × 0x01010101 (lane 0 is bits 7:0, lane 3 is bits 31:24).
- R3: The word written at base+4 is the bitwise complement of the pattern word written at base in the same step.
- R4: Each step issues, in this order: write pattern to base, write complement to base+4, read base, read base+4. The byte value starts at 0x00 and rises by one per step through 0xFF. A clean run therefore makes exactly 1024 accesses (512 writes, 512 reads).
- R5: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle. Read data is taken only in the acknowledge cycle.
- R6: On the first mismatch, `err` is set and `fail_addr`, `fail_exp` and `fail_obs` capture the address, expected word and read word. No further memory access follows.
- R7: `fail_lanes` bit i is set exactly when byte lane i of the failing word differs from the expected value.
- R8: `done` is high for exactly one cycle at the end of every run, pass or fail. `busy` is low in that cycle.
- R9: A start pulse while busy is ignored: the running sequence keeps its base address and access order.
- R10: A new start clears `err`, `fail_addr`, `fail_exp`, `fail_obs` and `fail_lanes` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run (taken in idle only) |
| base_addr | input | ADDR_W | Byte address of the word pair under test |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last run stopped on a mismatch |
| fail_addr | output | ADDR_W | Address of the failing word |
| fail_exp | output | DATA_W | Expected value of the failing word |
| fail_obs | output | DATA_W | Value read from the failing word |
| fail_lanes | output | DATA_W/8 | Per-lane mismatch mask of the failing word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
The bench builds the block with a 32-bit data path (four lanes) and a 16-bit address. This lets a small 16-word memory model hold both words of the pair at two different bases. The model acknowledges each access one cycle after the request, which exercises the hold-until-acknowledge path on every access. It can force chosen bits to one or zero on reads of one word. This places a failure on the pattern word or the complement word, in a chosen lane and at a chosen byte step. The test can therefore stop after 3, 4 or 7 accesses, and the bench checks the captured mask, address and data against hand-derived values.

// File: rtl/bln_pkg.sv
package bln_pkg;

    localparam int unsigned LANE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WR_PAT = 3'd1,
        ST_WR_INV = 3'd2,
        ST_RD_PAT = 3'd3,
        ST_RD_INV = 3'd4,
        ST_FINISH = 3'd5
    } bln_state_e;

endpackage

// File: rtl/bln_pattern_gen.sv
module bln_pattern_gen #(
    parameter int unsigned LANES = 4
) (
    input  logic [bln_pkg::LANE_W-1:0]       lane_val,
    output logic [LANES*bln_pkg::LANE_W-1:0] pat_word,
    output logic [LANES*bln_pkg::LANE_W-1:0] inv_word
);
    localparam int unsigned LW = bln_pkg::LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign pat_word[g*LW +: LW] = lane_val;
        assign inv_word[g*LW +: LW] = ~lane_val;
    end

endmodule

// File: rtl/bln_lane_compare.sv
module bln_lane_compare #(
    parameter int unsigned LANES = 4
) (
    input  logic [LANES*bln_pkg::LANE_W-1:0] expected,
    input  logic [LANES*bln_pkg::LANE_W-1:0] observed,
    output logic [LANES-1:0]                 lane_miss,
    output logic                             any_miss
);
    localparam int unsigned LW = bln_pkg::LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign lane_miss[g] = (expected[g*LW +: LW] != observed[g*LW +: LW]);
    end

    assign any_miss = |lane_miss;

endmodule

// File: rtl/bln_ctrl.sv
module bln_ctrl
    import bln_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [ADDR_W-1:0]      base_addr,
    input  logic                   mem_ack,
    input  logic [DATA_W-1:0]      mem_rdata,
    input  logic [DATA_W-1:0]      exp_word,
    input  logic [DATA_W/8-1:0]    lane_miss,
    input  logic                   any_miss,
    output logic [LANE_W-1:0]      lane_val,
    output logic                   word_hi,
    output logic                   busy,
    output logic                   done,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic                   err,
    output logic [ADDR_W-1:0]      fail_addr,
    output logic [DATA_W-1:0]      fail_exp,
    output logic [DATA_W-1:0]      fail_obs,
    output logic [DATA_W/8-1:0]    fail_lanes
);
    localparam int unsigned LANES  = DATA_W / 8;
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(LANES);
    localparam logic [LANE_W-1:0] LAST_VAL = '1;

    bln_state_e state, state_nx;
    logic [ADDR_W-1:0] base_q;
    logic [LANE_W-1:0] val_q;
    logic              rd_cmp;
    logic              hit_fail;

    assign rd_cmp   = mem_ack && (state == ST_RD_PAT || state == ST_RD_INV);
    assign hit_fail = rd_cmp && any_miss;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)   state_nx = ST_WR_PAT;
            ST_WR_PAT: if (mem_ack) state_nx = ST_WR_INV;
            ST_WR_INV: if (mem_ack) state_nx = ST_RD_PAT;
            ST_RD_PAT: if (mem_ack) state_nx = any_miss ? ST_FINISH : ST_RD_INV;
            ST_RD_INV: if (mem_ack) state_nx = (any_miss || val_q == LAST_VAL) ? ST_FINISH : ST_WR_PAT;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // datapath registers: base, byte value, failure capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            val_q      <= '0;
            err        <= 1'b0;
            fail_addr  <= '0;
            fail_exp   <= '0;
            fail_obs   <= '0;
            fail_lanes <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                base_q     <= base_addr;
                val_q      <= '0;
                err        <= 1'b0;
                fail_addr  <= '0;
                fail_exp   <= '0;
                fail_obs   <= '0;
                fail_lanes <= '0;
            end
            if (hit_fail) begin
                err        <= 1'b1;
                fail_addr  <= mem_addr;
                fail_exp   <= exp_word;
                fail_obs   <= mem_rdata;
                fail_lanes <= lane_miss;
            end else if (state == ST_RD_INV && mem_ack && val_q != LAST_VAL) begin
                val_q <= val_q + 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        word_hi = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_WR_PAT: begin mem_req = 1'b1; mem_we = 1'b1; busy = 1'b1; end
            ST_WR_INV: begin mem_req = 1'b1; mem_we = 1'b1; word_hi = 1'b1; busy = 1'b1; end
            ST_RD_PAT: begin mem_req = 1'b1; busy = 1'b1; end
            ST_RD_INV: begin mem_req = 1'b1; word_hi = 1'b1; busy = 1'b1; end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    assign lane_val = val_q;
    assign mem_addr = base_q + (word_hi ? STRIDE : '0);

endmodule

// File: rtl/bytelane_noise_tester.sv
module bytelane_noise_tester #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   base_addr,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [ADDR_W-1:0]   fail_addr,
    output logic [DATA_W-1:0]   fail_exp,
    output logic [DATA_W-1:0]   fail_obs,
    output logic [DATA_W/8-1:0] fail_lanes,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int unsigned LANES = DATA_W / 8;

    logic [bln_pkg::LANE_W-1:0] lane_val;
    logic [DATA_W-1:0] pat_word, inv_word, exp_word;
    logic [LANES-1:0]  lane_miss;
    logic              any_miss;
    logic              word_hi;

    bln_pattern_gen #(.LANES(LANES)) u_gen (
        .lane_val (lane_val),
        .pat_word (pat_word),
        .inv_word (inv_word)
    );

    assign exp_word  = word_hi ? inv_word : pat_word;
    assign mem_wdata = exp_word;

    bln_lane_compare #(.LANES(LANES)) u_cmp (
        .expected  (exp_word),
        .observed  (mem_rdata),
        .lane_miss (lane_miss),
        .any_miss  (any_miss)
    );

    bln_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .base_addr  (base_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .exp_word   (exp_word),
        .lane_miss  (lane_miss),
        .any_miss   (any_miss),
        .lane_val   (lane_val),
        .word_hi    (word_hi),
        .busy       (busy),
        .done       (done),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .err        (err),
        .fail_addr  (fail_addr),
        .fail_exp   (fail_exp),
        .fail_obs   (fail_obs),
        .fail_lanes (fail_lanes)
    );

endmodule

// File: rtl/bln_checker.sv
module bln_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                done,
    input logic                err,
    input logic [DATA_W/8-1:0] fail_lanes,
    input logic                mem_req,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic                mem_ack
);
    localparam int unsigned LANES = DATA_W / 8;

    function automatic logic all_lanes_equal(input logic [DATA_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 1; i < LANES; i++)
            if (w[i*8 +: 8] != w[7:0]) ok = 1'b0;
        return ok;
    endfunction

    // R2: every written word is a single byte repeated across lanes
    assert_lanes_replicated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> all_lanes_equal(mem_wdata));

    // R3: a write directly following an acknowledged write carries the complement
    assert_inverse_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $past(mem_req && mem_we && mem_ack)) |-> (mem_wdata == ~$past(mem_wdata)));

    // R5: request and its fields stay put until acknowledged
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R6: once an error is flagged, no access is issued
    assert_stop_on_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_req);

    // R7: a flagged error always names at least one lane
    assert_lane_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (fail_lanes != '0));

    // R8: done lasts a single cycle and marks the end of busy
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_end_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind bytelane_noise_tester bln_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bln_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .fail_lanes (fail_lanes),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/tb_bytelane_noise_tester.sv
module tb_bytelane_noise_tester;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic busy, done, err;
    logic [ADDR_W-1:0] fail_addr;
    logic [DATA_W-1:0] fail_exp, fail_obs;
    logic [3:0] fail_lanes;
    logic mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bytelane_noise_tester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .busy(busy), .done(done), .err(err), .fail_addr(fail_addr),
        .fail_exp(fail_exp), .fail_obs(fail_obs), .fail_lanes(fail_lanes),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model: acknowledge one cycle after request, optional read fault
    logic [DATA_W-1:0] mem [16];
    logic [3:0]        f_idx = '0;
    logic [DATA_W-1:0] f_set = '0;
    logic [DATA_W-1:0] f_clr = '0;

    always_ff @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
            else if (mem_addr[5:2] == f_idx)
                mem_rdata <= (mem[mem_addr[5:2]] | f_set) & ~f_clr;
            else
                mem_rdata <= mem[mem_addr[5:2]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // access monitor: compares every completed access with the expected order
    int                acc_k = 0;
    int                seq_bad = 0;
    logic [ADDR_W-1:0] run_base = '0;

    always @(negedge clk) begin
        if (mem_req && mem_ack) begin
            automatic int ph = acc_k % 4;
            automatic logic [7:0] bv = 8'(acc_k / 4);
            automatic logic [31:0] rep = {4{bv}};
            automatic logic [ADDR_W-1:0] ea = run_base + ((ph == 1 || ph == 3) ? 16'd4 : 16'd0);
            if (mem_addr != ea || mem_we != (ph < 2)) seq_bad++;
            else if (ph == 0 && mem_wdata != rep) seq_bad++;
            else if (ph == 1 && mem_wdata != ~rep) seq_bad++;
            acc_k++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic kick(input logic [ADDR_W-1:0] b);
        @(negedge clk);
        acc_k = 0; seq_bad = 0; run_base = b;
        base_addr = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    endtask

    task automatic test_reset();
        check(busy == 0, "R8", "busy after reset", 32'(busy), 0);
        check(done == 0, "R8", "done after reset", 32'(done), 0);
        check(err == 0, "R6", "err after reset", 32'(err), 0);
        check(mem_req == 0, "R1", "mem_req after reset", 32'(mem_req), 0);
    endtask

    task automatic test_clean(input logic [ADDR_W-1:0] b);
        int cyc;
        kick(b);
        check(busy == 1, "R1", "busy after start", 32'(busy), 1);
        check(mem_req && mem_we && mem_addr == b && mem_wdata == 0, "R1", "first access addr",
              32'(mem_addr), 32'(b));
        wait_done(cyc);
        check(done == 1, "R8", "done reached", 32'(done), 1);
        check(busy == 0, "R8", "busy in done cycle", 32'(busy), 0);
        check(err == 0, "R6", "err on clean run", 32'(err), 0);
        check(acc_k == 1024, "R4", "access count", 32'(acc_k), 1024);
        check(seq_bad == 0, "R2", "pattern/order mismatches (R3 R4)", 32'(seq_bad), 0);
        check(fail_addr == 0 && fail_lanes == 0, "R10", "failure fields cleared",
              32'(fail_addr), 0);
        @(negedge clk);
        check(done == 0, "R8", "done one cycle", 32'(done), 0);
    endtask

    task automatic test_fault(input string tag, input logic [3:0] idx, input logic [31:0] s,
                              input logic [31:0] c, input logic [ADDR_W-1:0] ea,
                              input logic [31:0] ee, input logic [31:0] eo,
                              input logic [3:0] el, input int ek);
        int cyc;
        f_idx = idx; f_set = s; f_clr = c;
        kick(16'h0010);
        wait_done(cyc);
        check(done == 1 && err == 1, "R6", {tag, " err with done"}, 32'(err), 1);
        check(fail_addr == ea, "R6", {tag, " fail_addr"}, 32'(fail_addr), 32'(ea));
        check(fail_exp == ee, "R6", {tag, " fail_exp"}, fail_exp, ee);
        check(fail_obs == eo, "R6", {tag, " fail_obs"}, fail_obs, eo);
        check(fail_lanes == el, "R7", {tag, " fail_lanes"}, 32'(fail_lanes), 32'(el));
        repeat (10) @(negedge clk);
        check(acc_k == ek, "R6", {tag, " no access after fail"}, 32'(acc_k), 32'(ek));
        check(err == 1 && !busy, "R6", {tag, " stays stopped"}, 32'(busy), 0);
        f_set = '0; f_clr = '0;
    endtask

    task automatic test_start_busy();
        int cyc;
        kick(16'h0010);
        repeat (100) @(negedge clk);
        base_addr = 16'h0020; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        check(seq_bad == 0, "R9", "base kept despite start", 32'(seq_bad), 0);
        check(acc_k == 1024, "R9", "access count with start while busy", 32'(acc_k), 1024);
    endtask

    initial begin
        int wd = 0;
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                test_reset();
                test_clean(16'h0010);
                // lane 3 stuck high on base word: first read of 0x00000000 fails
                test_fault("stuck1", 4'd4, 32'h0100_0000, 32'h0, 16'h0010,
                           32'h0000_0000, 32'h0100_0000, 4'b1000, 3);
                // lane 1 bit low on base+4: complement of byte 0 fails
                test_fault("inv", 4'd5, 32'h0, 32'h0000_0200, 16'h0014,
                           32'hFFFF_FFFF, 32'hFFFF_FDFF, 4'b0010, 4);
                // lane 0 bit 0 low on base: passes byte 0, fails byte 1
                test_fault("step", 4'd4, 32'h0, 32'h0000_0001, 16'h0010,
                           32'h0101_0101, 32'h0101_0100, 4'b0001, 7);
                test_clean(16'h0020);
                test_start_busy();
            end
            begin
                while (wd < 100000) begin @(negedge clk); wd++; end
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule